// File: doc/BRIEF.md
# CD Sector Decode Status Controller

This block runs the per-sector decode cycle of an optical-disc data decoder whose write path stores incoming sector bytes in a 16 KB circular buffer RAM. Each time the write path signals a sector boundary, the block marks the header and status bytes as stale. It also drives the active-low decode interrupt inactive. If decoding is enabled, it starts a fixed-length decode timer. If writing is also requested, it moves the block pointer back one full 2352-byte sector from the current write address.

When the timer expires, the block asserts the decode interrupt (drives it low), marks the status as valid and sets the CRC-OK flag. With write request set, it then fetches four header bytes from the buffer RAM, one per clock, starting at the block pointer. A byte-wide register port lets a host read the headers, the pointer and two status bytes. Reading the second status byte releases the interrupt. The host may also overwrite the pointer bytes.

Top module: `cd_sector_decode_ctrl`

## Requirements
- R1: A synchronous reset drives dec_irq_n_o to 1, stat_invalid_o to 1 and crc_ok_o to 0. It clears the pointer and all header bytes and leaves the timer idle, so no completion follows the reset.
- R2: In the cycle after any sector event, dec_irq_n_o is 1 and stat_invalid_o is 1, whatever the state of dec_en_i.
- R3: A sector event with dec_en_i and wr_req_i both set loads the pointer with (wr_addr_i - 2352) mod 65536. The pointer is read at register address 4 (bits 7:0) and address 5 (bits 15:8).
- R4: A sector event starts a decode only when dec_en_i is set. Exactly SECTOR_BYTES*4*CLK_STEP clocks (9408 by default) after the event edge, dec_irq_n_o and stat_invalid_o go to 0 and crc_ok_o goes to 1. Only a reset clears crc_ok_o again. With dec_en_i clear, no completion follows.
- R5: At completion with wr_req_i set, register addresses 0 to 3 receive buffer bytes at (pointer + i) mod 16384 for i = 0..3, fetched in order at one byte per clock over the following cycles. With wr_req_i clear, the header bytes keep their values.
- R6: A read strobe returns data on reg_rdata_o one clock later. Address 6 returns {crc_ok, 7'b0}, address 7 returns {stat_invalid, 7'b0}, and addresses 8 to 15 return 8'hFF.
- R7: A read of address 7 drives dec_irq_n_o to 1 in the next cycle.
- R8: Host writes to address 4 or 5 change only the addressed pointer byte and start no decode. Writes to addresses 0 to 3, 6 and 7 are ignored.
- R9: A sector event arriving during a decode restarts the timer. If it arrives in the very cycle the running decode would complete, that completion is discarded: the flags stay not-valid and inactive, and no headers load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_en_i | input | 1 | Decode enable control bit |
| wr_req_i | input | 1 | Write request control bit |
| sector_evt_i | input | 1 | One-cycle sector boundary strobe from the write path |
| wr_addr_i | input | 16 | Current buffer write address at the sector event |
| reg_addr_i | input | 4 | Host register address |
| reg_we_i | input | 1 | Host register write strobe |
| reg_wdata_i | input | 8 | Host register write data |
| reg_re_i | input | 1 | Host register read strobe |
| reg_rdata_o | output | 8 | Registered host read data |
| buf_raddr_o | output | 14 | Buffer RAM read address (registered) |
| buf_rdata_i | input | 8 | Buffer RAM read data, one clock after the address |
| dec_irq_n_o | output | 1 | Active-low decode interrupt |
| stat_invalid_o | output | 1 | High while header and status bytes are not valid |
| crc_ok_o | output | 1 | CRC-OK flag |

## Verification
A sector event and the completion of the previous decode can land on the same clock edge. The bench provokes this by timing a second sector strobe so that its capturing edge is exactly 9408 clocks after the first event. It then judges that the interrupt and valid flag stay in their inactive, not-valid state and that the header bytes remain untouched. It also confirms that the restarted decode completes a full 9408 clocks later and loads headers from the new pointer.

// File: rtl/cdsd_pkg.sv
package cdsd_pkg;
  localparam int PTR_W   = 16;
  localparam int RA_W    = 4;
  localparam int HDR_N   = 4;
  localparam int HDR_IW  = 2;

  localparam logic [RA_W-1:0] RA_PTR_LO = 4'd4;
  localparam logic [RA_W-1:0] RA_PTR_HI = 4'd5;
  localparam logic [RA_W-1:0] RA_STATA  = 4'd6;
  localparam logic [RA_W-1:0] RA_STATB  = 4'd7;
endpackage

// File: rtl/cdsd_decode_timer.sv
module cdsd_decode_timer #(
  parameter int LIMIT = 9408,
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (start_i)           cnt_q <= CNT_W'(LIMIT);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  // a fresh start in the final cycle discards the expiring decode
  assign done_o = (cnt_q == CNT_W'(1)) && !start_i;
endmodule

// File: rtl/cdsd_header_loader.sv
module cdsd_header_loader
  import cdsd_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [AW-1:0]     base_i,
  output logic [AW-1:0]     raddr_o,
  input  logic [7:0]        rdata_i,
  output logic              wr_en_o,
  output logic [HDR_IW-1:0] wr_idx_o,
  output logic [7:0]        wr_data_o
);
  logic              issue_v_q, cap_v_q;
  logic [HDR_IW-1:0] issue_idx_q, cap_idx_q;
  logic [AW-1:0]     raddr_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      issue_v_q   <= 1'b0;
      cap_v_q     <= 1'b0;
      issue_idx_q <= '0;
      cap_idx_q   <= '0;
      raddr_q     <= '0;
    end else begin
      cap_v_q   <= issue_v_q;
      cap_idx_q <= issue_idx_q;
      if (start_i) begin
        issue_v_q   <= 1'b1;
        issue_idx_q <= '0;
        raddr_q     <= base_i;
      end else if (issue_v_q) begin
        raddr_q <= raddr_q + AW'(1);
        if (issue_idx_q == HDR_IW'(HDR_N - 1)) issue_v_q <= 1'b0;
        else issue_idx_q <= issue_idx_q + HDR_IW'(1);
      end
    end
  end

  assign raddr_o   = raddr_q;
  assign wr_en_o   = cap_v_q;
  assign wr_idx_o  = cap_idx_q;
  assign wr_data_o = rdata_i;
endmodule

// File: rtl/cdsd_status_flags.sv
module cdsd_status_flags (
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic done_i,
  input  logic statb_rd_i,
  output logic irq_n_o,
  output logic invalid_o,
  output logic crc_ok_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_o   <= 1'b1;
      invalid_o <= 1'b1;
      crc_ok_o  <= 1'b0;
    end else if (evt_i) begin
      irq_n_o   <= 1'b1;
      invalid_o <= 1'b1;
    end else if (done_i) begin
      irq_n_o   <= 1'b0;
      invalid_o <= 1'b0;
      crc_ok_o  <= 1'b1;
    end else if (statb_rd_i) begin
      irq_n_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/cd_sector_decode_ctrl.sv
module cd_sector_decode_ctrl
  import cdsd_pkg::*;
#(
  parameter int SECTOR_BYTES = 2352,
  parameter int CLK_STEP     = 1,
  parameter int BUF_AW       = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_en_i,
  input  logic              wr_req_i,
  input  logic              sector_evt_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              reg_re_i,
  output logic [7:0]        reg_rdata_o,
  output logic [BUF_AW-1:0] buf_raddr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              dec_irq_n_o,
  output logic              stat_invalid_o,
  output logic              crc_ok_o
);
  localparam int DECODE_CYCLES = SECTOR_BYTES * 4 * CLK_STEP;
  localparam int CNT_W         = $clog2(DECODE_CYCLES + 1);

  logic              dec_start, dec_done, ld_start, statb_rd;
  logic              ld_we;
  logic [HDR_IW-1:0] ld_idx;
  logic [7:0]        ld_data;
  logic [PTR_W-1:0]  ptr_q;
  logic [7:0]        hdr_q [HDR_N];
  logic [7:0]        rd_mux;

  assign dec_start = sector_evt_i && dec_en_i;
  assign ld_start  = dec_done && wr_req_i;
  assign statb_rd  = reg_re_i && (reg_addr_i == RA_STATB);

  cdsd_decode_timer #(.LIMIT(DECODE_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .start_i(dec_start), .done_o(dec_done)
  );

  cdsd_header_loader #(.AW(BUF_AW)) u_loader (
    .clk(clk), .rst(rst), .start_i(ld_start), .abort_i(sector_evt_i),
    .base_i(ptr_q[BUF_AW-1:0]), .raddr_o(buf_raddr_o), .rdata_i(buf_rdata_i),
    .wr_en_o(ld_we), .wr_idx_o(ld_idx), .wr_data_o(ld_data)
  );

  cdsd_status_flags u_flags (
    .clk(clk), .rst(rst), .evt_i(sector_evt_i), .done_i(dec_done),
    .statb_rd_i(statb_rd), .irq_n_o(dec_irq_n_o),
    .invalid_o(stat_invalid_o), .crc_ok_o(crc_ok_o)
  );

  // block pointer: sector event has priority over host writes
  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (dec_start && wr_req_i) ptr_q <= wr_addr_i - PTR_W'(SECTOR_BYTES);
    else if (reg_we_i && reg_addr_i == RA_PTR_LO) ptr_q[7:0] <= reg_wdata_i;
    else if (reg_we_i && reg_addr_i == RA_PTR_HI) ptr_q[PTR_W-1:8] <= reg_wdata_i;
  end

  for (genvar gi = 0; gi < HDR_N; gi++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (rst) hdr_q[gi] <= '0;
      else if (ld_we && ld_idx == HDR_IW'(gi)) hdr_q[gi] <= ld_data;
    end
  end

  always_comb begin
    rd_mux = 8'hFF;
    if (reg_addr_i < RA_W'(HDR_N)) rd_mux = hdr_q[reg_addr_i[HDR_IW-1:0]];
    else if (reg_addr_i == RA_PTR_LO) rd_mux = ptr_q[7:0];
    else if (reg_addr_i == RA_PTR_HI) rd_mux = ptr_q[PTR_W-1:8];
    else if (reg_addr_i == RA_STATA)  rd_mux = {crc_ok_o, 7'b0};
    else if (reg_addr_i == RA_STATB)  rd_mux = {stat_invalid_o, 7'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else if (reg_re_i) reg_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/cdsd_checker.sv
module cdsd_checker (
  input logic       clk,
  input logic       rst,
  input logic       sector_evt_i,
  input logic       reg_re_i,
  input logic [3:0] reg_addr_i,
  input logic       dec_irq_n_o,
  input logic       stat_invalid_o,
  input logic       crc_ok_o,
  input logic       dec_done
);
  a_r2_evt_clears: assert property (@(posedge clk) disable iff (rst)
    sector_evt_i |=> (dec_irq_n_o && stat_invalid_o));

  a_r4_done_flags: assert property (@(posedge clk) disable iff (rst)
    dec_done |=> (!dec_irq_n_o && !stat_invalid_o && crc_ok_o));

  a_r4_crc_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(crc_ok_o)) |-> crc_ok_o);

  a_r4_irq_falls_on_done: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(dec_irq_n_o)) |-> $past(dec_done));

  a_r7_statb_release: assert property (@(posedge clk) disable iff (rst)
    (reg_re_i && reg_addr_i == 4'd7 && !dec_done) |=> dec_irq_n_o);
endmodule

bind cd_sector_decode_ctrl cdsd_checker u_chk (
  .clk(clk), .rst(rst), .sector_evt_i(sector_evt_i), .reg_re_i(reg_re_i),
  .reg_addr_i(reg_addr_i), .dec_irq_n_o(dec_irq_n_o),
  .stat_invalid_o(stat_invalid_o), .crc_ok_o(crc_ok_o), .dec_done(dec_done)
);

// File: tb/cd_sector_decode_ctrl_test.sv
`timescale 1ns/1ps
module cd_sector_decode_ctrl_test;
  localparam int N  = 2352 * 4;
  localparam int NV = 5;
  // {write address, dec_en, wr_req, expected pointer}
  localparam logic [33:0] VEC [NV] = '{
    {16'h1000, 1'b1, 1'b1, 16'h06D0},
    {16'h0100, 1'b1, 1'b1, 16'hF7D0},
    {16'h2000, 1'b1, 1'b0, 16'hF7D0},
    {16'h492E, 1'b1, 1'b1, 16'h3FFE},
    {16'h1234, 1'b0, 1'b1, 16'h3FFE}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic dec_en = 0, wr_req = 0, sector_evt = 0, reg_we = 0, reg_re = 0;
  logic [15:0] wr_addr = '0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata, buf_rdata = '0;
  logic [13:0] buf_raddr;
  logic irq_n, invalid, crc_ok;
  int compared = 0, mismatched = 0;
  logic [7:0] m_hdr [4];
  logic [15:0] m_ptr;
  logic [7:0] rv;

  always #2 clk = ~clk;

  cd_sector_decode_ctrl uut (
    .clk(clk), .rst(rst), .dec_en_i(dec_en), .wr_req_i(wr_req),
    .sector_evt_i(sector_evt), .wr_addr_i(wr_addr), .reg_addr_i(reg_addr),
    .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_re_i(reg_re),
    .reg_rdata_o(reg_rdata), .buf_raddr_o(buf_raddr), .buf_rdata_i(buf_rdata),
    .dec_irq_n_o(irq_n), .stat_invalid_o(invalid), .crc_ok_o(crc_ok)
  );

  function automatic logic [7:0] bufval(input logic [13:0] a);
    return a[7:0] ^ {2'b10, a[13:8]};
  endfunction

  always @(posedge clk) buf_rdata <= bufval(buf_raddr);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sector(input logic [15:0] a, input logic en, input logic wr);
    @(negedge clk);
    sector_evt = 1; wr_addr = a; dec_en = en; wr_req = wr;
    @(negedge clk);
    sector_evt = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a;
    @(negedge clk); reg_re = 0; d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic check_hdrs_ptr(input string req);
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), rv); chk(req, rv, m_hdr[i]);
    end
    rd(4'd4, rv); chk("R3 ptr lo", rv, m_ptr[7:0]);
    rd(4'd5, rv); chk("R3 ptr hi", rv, m_ptr[15:8]);
  endtask

  task automatic model_load();
    for (int i = 0; i < 4; i++) m_hdr[i] = bufval(14'(m_ptr + 16'(i)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_hdr[i] = 8'h00;
    m_ptr = 16'h0000;
    wait_n(3); rst = 0; wait_n(1);
    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 invalid", {7'b0, invalid}, 8'h01);
    chk("R1 crc", {7'b0, crc_ok}, 8'h00);
    check_hdrs_ptr("R1 hdr");
    rd(4'd6, rv); chk("R6 stat A reset", rv, 8'h00);
    rd(4'd7, rv); chk("R6 stat B reset", rv, 8'h80);
    rd(4'd9, rv); chk("R6 unmapped 9", rv, 8'hFF);
    rd(4'd15, rv); chk("R6 unmapped 15", rv, 8'hFF);
    // R8 host pointer write: updates bytes only, starts nothing
    wr(4'd5, 8'h12); wr(4'd4, 8'h34); m_ptr = 16'h1234;
    rd(4'd4, rv); chk("R8 ptr lo", rv, 8'h34);
    rd(4'd5, rv); chk("R8 ptr hi", rv, 8'h12);
    wait_n(N + 8);
    chk("R8 no decode irq", {7'b0, irq_n}, 8'h01);
    chk("R8 no decode valid", {7'b0, invalid}, 8'h01);

    for (int v = 0; v < NV; v++) begin
      logic [15:0] a; logic en, w; logic [15:0] ep;
      {a, en, w, ep} = VEC[v];
      sector(a, en, w);
      chk($sformatf("R2 v%0d irq_n", v), {7'b0, irq_n}, 8'h01);
      chk($sformatf("R2 v%0d invalid", v), {7'b0, invalid}, 8'h01);
      m_ptr = ep;
      if (en) begin
        wait_n(N - 1);
        chk($sformatf("R4 v%0d before", v), {7'b0, irq_n}, 8'h01);
        wait_n(1);
        chk($sformatf("R4 v%0d irq low", v), {7'b0, irq_n}, 8'h00);
        chk($sformatf("R4 v%0d valid", v), {7'b0, invalid}, 8'h00);
        chk($sformatf("R4 v%0d crc", v), {7'b0, crc_ok}, 8'h01);
        if (w) model_load();
        wait_n(8);
        check_hdrs_ptr($sformatf("R5 v%0d hdr", v));
        rd(4'd6, rv); chk("R6 stat A", rv, 8'h80);
        rd(4'd7, rv); chk("R6 stat B valid", rv, 8'h00);
        wait_n(1);
        chk($sformatf("R7 v%0d release", v), {7'b0, irq_n}, 8'h01);
      end else begin
        wait_n(N + 8);
        chk("R4 no en irq", {7'b0, irq_n}, 8'h01);
        chk("R4 no en invalid", {7'b0, invalid}, 8'h01);
        check_hdrs_ptr("R4 no en hdr");
        rd(4'd6, rv); chk("R4 crc sticky", rv, 8'h80);
      end
    end

    // R8 writes to header and status addresses are ignored
    wr(4'd0, 8'hAA); wr(4'd6, 8'h00); wr(4'd7, 8'h00);
    rd(4'd0, rv); chk("R8 hdr write ignored", rv, m_hdr[0]);
    rd(4'd6, rv); chk("R8 stat A write ignored", rv, 8'h80);
    rd(4'd7, rv); chk("R8 stat B write ignored", rv, 8'h80);

    // R9 sector event on the completion edge of the running decode
    sector(16'h0A00, 1'b1, 1'b1);
    wait_n(N - 2);
    sector(16'h1930, 1'b1, 1'b1);
    chk("R9 collide irq_n", {7'b0, irq_n}, 8'h01);
    chk("R9 collide invalid", {7'b0, invalid}, 8'h01);
    wait_n(8);
    for (int i = 0; i < 4; i++) begin
      rd(4'(i), rv); chk("R9 no load on discard", rv, m_hdr[i]);
    end
    wait_n(N - 1 - 8 - 8);
    chk("R9 restart before", {7'b0, irq_n}, 8'h01);
    wait_n(1);
    chk("R9 restart done", {7'b0, irq_n}, 8'h00);
    m_ptr = 16'h1000; model_load();
    wait_n(8);
    check_hdrs_ptr("R9 new hdr");

    // R1 reset during a decode
    sector(16'h2000, 1'b1, 1'b1);
    wait_n(50);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 mid irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 mid invalid", {7'b0, invalid}, 8'h01);
    chk("R1 mid crc", {7'b0, crc_ok}, 8'h00);
    wait_n(N + 8);
    chk("R1 timer idle irq", {7'b0, irq_n}, 8'h01);
    chk("R1 timer idle crc", {7'b0, crc_ok}, 8'h00);
    rd(4'd4, rv); chk("R1 ptr cleared", rv, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule